// File: doc/BRIEF.md
# Transfer Descriptor Completion Updater

This block is the decision step that closes out one bus transaction for a host controller that walks transfer descriptors. It receives the descriptor's control/status word, its token word, the outcome the bus engine reported (success with a received or sent byte count, stall, babble, NAK or timeout) and returns three things. The first is the rewritten control/status word to store back. The second is a two-bit verdict telling the list walker what to do next. The third is a set of event flags that the interrupt logic collects for the end of the frame.

The block holds no descriptor memory and drives no bus. A request is accepted with a valid/ready handshake, evaluated combinationally and presented one cycle later through a single-entry output register. The output register may be replaced by a pass-through. The output holds steady while the consumer stalls.

Verdict encoding (out_result): 0 = done (advance the queue), 1 = skip (leave the queue where it is), 2 = pending (try again in a later frame), 3 = fatal (abandon the frame). Outcome encoding (in_outcome): 0 success, 1 stall, 2 babble, 3 NAK, 4 timeout; codes 5 to 7 are handled as stall. Packet ID codes are IN = 0x69, OUT = 0xE1, SETUP = 0x2D.

Top module: `td_complete_updater`

## Requirements
- R1: The allowed length is (token[31:21] + 1) reduced modulo 2048, so a field of 0x7FF means zero bytes. The packet ID is token[7:0].
- R2: A descriptor whose active bit (ctrl bit 23) is clear yields skip, an unchanged word and no events, whatever the outcome.
- R3: On success, ctrl[10:0] becomes (count − 1) modulo 2048, active (bit 23) and NAK (bit 19) are cleared, and the verdict is done. The completion event is raised when ctrl bit 24 is set.
- R4: On success with short-packet detect (bit 29) set and count below the allowed length, the short event is raised and the verdict is skip.
- R5: On success of an IN packet with count above the allowed length, the length field and the active/NAK clearing of R3 apply. In addition, babble (bit 20) and stalled (bit 22) are set, the USB error event is raised, the completion event follows bit 24, and the verdict is fatal.
- R6: A stall (or outcome code 5 to 7) sets bit 22 and clears bit 23. It raises the USB error event, raises the completion event when bit 24 is set, and gives skip.
- R7: A babble outcome sets bits 20 and 22 and clears bit 23. It raises the USB error event, raises the completion event when bit 24 is set, and gives fatal.
- R8: A NAK on a non-SETUP packet sets bit 19, keeps bit 23 and gives pending with no events.
- R9: A NAK on a SETUP packet sets bit 19 and is then treated as a timeout.
- R10: A timeout sets bit 18 and decrements the error count held in bits 28:27. If the count reaches zero, bit 23 is cleared, the USB error event is raised, the completion event follows bit 24 and the verdict is skip. Otherwise the verdict is pending and the word stays active.
- R11: A timeout with an error count of zero on entry keeps the count at zero, stays active, raises no events and gives pending.
- R12: For an active descriptor with the isochronous bit (25) set, bit 23 is cleared after any outcome, and a pending verdict turns into skip.
- R13: With the registered output, in_ready equals (not out_valid) or out_ready, results appear one cycle after acceptance, and the output fields hold while out_valid is high and out_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_ctrl | input | 32 | Descriptor control/status word |
| in_token | input | 32 | Descriptor token word |
| in_outcome | input | 3 | Transaction outcome code |
| in_count | input | 12 | Bytes moved on success |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ctrl | output | 32 | Rewritten control/status word |
| out_result | output | 2 | Verdict: done, skip, pending, fatal |
| out_ioc | output | 1 | Completion interrupt event |
| out_short | output | 1 | Short packet event |
| out_usb_err | output | 1 | USB error event |

## Verification
Every cycle, the checker enforces relations visible at the output alone. A fatal verdict always carries babble and stall marks with active clear. Short events only come with skip. Pending never leaves a word inactive or flags an error. An error event always retires the word. An isochronous word never leaves active. The handshake holds its data under backpressure. Relations that tie the output to a particular input cannot be shown from the output alone and are covered only by the bench's sweep: the length arithmetic, the error countdown and its floor at zero, the SETUP NAK redirect and the untouched word for an inactive descriptor.

// File: rtl/td_upd_pkg.sv
package td_upd_pkg;
   // control/status word layout (consumers decode these positions)
   localparam int LEN_W      = 11;
   localparam int CNT_W      = LEN_W + 1;
   localparam int ERR_W      = 2;
   localparam int B_SPD      = 29;
   localparam int B_ERR_LO   = 27;
   localparam int B_ISO      = 25;
   localparam int B_IOC      = 24;
   localparam int B_ACT      = 23;
   localparam int B_STALL    = 22;
   localparam int B_BABBLE   = 20;
   localparam int B_NAK      = 19;
   localparam int B_TMO      = 18;
   localparam int TOK_MAX_LO = 21;

   typedef enum logic [2:0] {
      OC_OK      = 3'd0,
      OC_STALL   = 3'd1,
      OC_BABBLE  = 3'd2,
      OC_NAK     = 3'd3,
      OC_TIMEOUT = 3'd4
   } outcome_e;

   typedef enum logic [1:0] {
      RES_DONE    = 2'd0,
      RES_SKIP    = 2'd1,
      RES_PENDING = 2'd2,
      RES_FATAL   = 2'd3
   } result_e;
endpackage

// File: rtl/td_field_decode.sv
module td_field_decode
   import td_upd_pkg::*;
#(
   parameter int          WORD_W    = 32,
   parameter logic [7:0]  PID_IN    = 8'h69,
   parameter logic [7:0]  PID_SETUP = 8'h2D
) (
   input  logic [WORD_W-1:0] token,
   output logic [CNT_W-1:0]  max_len,
   output logic              is_in,
   output logic              is_setup
);
   logic [LEN_W-1:0] max_field;
   logic [LEN_W-1:0] max_wrapped;
   logic [7:0]       pid;

   assign max_field   = token[TOK_MAX_LO +: LEN_W];
   assign max_wrapped = max_field + LEN_W'(1);
   assign max_len     = {1'b0, max_wrapped};
   assign pid         = token[7:0];
   assign is_in       = (pid == PID_IN);
   assign is_setup    = (pid == PID_SETUP);
endmodule

// File: rtl/td_status_eval.sv
module td_status_eval
   import td_upd_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] ctrl,
   input  logic [2:0]        outcome,
   input  logic [CNT_W-1:0]  count,
   input  logic [CNT_W-1:0]  max_len,
   input  logic              is_in,
   input  logic              is_setup,
   output logic [WORD_W-1:0] new_ctrl,
   output result_e           result,
   output logic              ev_ioc,
   output logic              ev_short,
   output logic              ev_err
);
   logic [ERR_W-1:0] err_in;
   logic [ERR_W-1:0] err_nx;
   logic [LEN_W-1:0] len_m1;
   logic             overflow;
   logic             short_pkt;
   outcome_e         eff;

   assign err_in    = ctrl[B_ERR_LO +: ERR_W];
   assign len_m1    = count[LEN_W-1:0] - LEN_W'(1);
   assign overflow  = is_in && (count > max_len);
   assign short_pkt = ctrl[B_SPD] && (count < max_len);

   always_comb begin
      new_ctrl = ctrl;
      result   = RES_DONE;
      ev_ioc   = 1'b0;
      ev_short = 1'b0;
      ev_err   = 1'b0;
      err_nx   = err_in;
      if (outcome > 3'd4) eff = OC_STALL;
      else                eff = outcome_e'(outcome);

      if (!ctrl[B_ACT]) begin
         result = RES_SKIP;
      end else begin
         if (eff == OC_NAK && is_setup) begin
            new_ctrl[B_NAK] = 1'b1;
            eff = OC_TIMEOUT;
         end
         case (eff)
            OC_OK: begin
               new_ctrl[LEN_W-1:0] = len_m1;
               new_ctrl[B_ACT]     = 1'b0;
               new_ctrl[B_NAK]     = 1'b0;
               ev_ioc              = ctrl[B_IOC];
               if (overflow) begin
                  new_ctrl[B_BABBLE] = 1'b1;
                  new_ctrl[B_STALL]  = 1'b1;
                  ev_err             = 1'b1;
                  result             = RES_FATAL;
               end else if (short_pkt) begin
                  ev_short = 1'b1;
                  result   = RES_SKIP;
               end
            end
            OC_BABBLE: begin
               new_ctrl[B_BABBLE] = 1'b1;
               new_ctrl[B_STALL]  = 1'b1;
               new_ctrl[B_ACT]    = 1'b0;
               ev_err             = 1'b1;
               ev_ioc             = ctrl[B_IOC];
               result             = RES_FATAL;
            end
            OC_NAK: begin
               new_ctrl[B_NAK] = 1'b1;
               result          = RES_PENDING;
            end
            OC_TIMEOUT: begin
               new_ctrl[B_TMO] = 1'b1;
               result          = RES_PENDING;
               if (err_in != '0) begin
                  err_nx = err_in - ERR_W'(1);
                  if (err_nx == '0) begin
                     new_ctrl[B_ACT] = 1'b0;
                     ev_err          = 1'b1;
                     ev_ioc          = ctrl[B_IOC];
                     result          = RES_SKIP;
                  end
               end
               new_ctrl[B_ERR_LO +: ERR_W] = err_nx;
            end
            default: begin
               new_ctrl[B_STALL] = 1'b1;
               new_ctrl[B_ACT]   = 1'b0;
               ev_err            = 1'b1;
               ev_ioc            = ctrl[B_IOC];
               result            = RES_SKIP;
            end
         endcase
         if (ctrl[B_ISO]) begin
            new_ctrl[B_ACT] = 1'b0;
            if (result == RES_PENDING) result = RES_SKIP;
         end
      end
   end
endmodule

// File: rtl/td_out_stage.sv
module td_out_stage #(
   parameter int W          = 8,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   generate
      if (REGISTERED) begin : g_reg
         logic         vld_q;
         logic [W-1:0] data_q;
         assign in_ready  = !vld_q || out_ready;
         assign out_valid = vld_q;
         assign out_data  = data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               data_q <= '0;
            end else if (in_ready) begin
               vld_q <= in_valid;
               if (in_valid) data_q <= in_data;
            end
         end
      end else begin : g_pass
         assign in_ready  = out_ready;
         assign out_valid = in_valid;
         assign out_data  = in_data;
      end
   endgenerate
endmodule

// File: rtl/td_complete_updater.sv
module td_complete_updater
   import td_upd_pkg::*;
#(
   parameter int         WORD_W    = 32,
   parameter bit         REG_OUT   = 1'b1,
   parameter logic [7:0] PID_IN    = 8'h69,
   parameter logic [7:0] PID_OUT   = 8'hE1,
   parameter logic [7:0] PID_SETUP = 8'h2D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_ctrl,
   input  logic [WORD_W-1:0] in_token,
   input  logic [2:0]        in_outcome,
   input  logic [CNT_W-1:0]  in_count,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_ctrl,
   output logic [1:0]        out_result,
   output logic              out_ioc,
   output logic              out_short,
   output logic              out_usb_err
);
   localparam int PAY_W = WORD_W + 2 + 3;

   if (WORD_W != 32) begin : g_bad_width
      $error("td_complete_updater: WORD_W must be 32 to match the field layout");
   end
   if (PID_IN == PID_SETUP || PID_IN == PID_OUT || PID_OUT == PID_SETUP) begin : g_bad_pid
      $error("td_complete_updater: packet ID codes must be distinct");
   end

   logic [CNT_W-1:0]  max_len;
   logic              is_in;
   logic              is_setup;
   logic [WORD_W-1:0] nx_ctrl;
   result_e           nx_result;
   logic              nx_ioc;
   logic              nx_short;
   logic              nx_err;
   logic [PAY_W-1:0]  pay_in;
   logic [PAY_W-1:0]  pay_out;

   td_field_decode #(
      .WORD_W   (WORD_W),
      .PID_IN   (PID_IN),
      .PID_SETUP(PID_SETUP)
   ) i_decode (
      .token   (in_token),
      .max_len (max_len),
      .is_in   (is_in),
      .is_setup(is_setup)
   );

   td_status_eval #(.WORD_W(WORD_W)) i_eval (
      .ctrl    (in_ctrl),
      .outcome (in_outcome),
      .count   (in_count),
      .max_len (max_len),
      .is_in   (is_in),
      .is_setup(is_setup),
      .new_ctrl(nx_ctrl),
      .result  (nx_result),
      .ev_ioc  (nx_ioc),
      .ev_short(nx_short),
      .ev_err  (nx_err)
   );

   assign pay_in = {nx_ctrl, nx_result, nx_ioc, nx_short, nx_err};

   td_out_stage #(.W(PAY_W), .REGISTERED(REG_OUT)) i_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (pay_in),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_data (pay_out)
   );

   assign out_ctrl    = pay_out[PAY_W-1 -: WORD_W];
   assign out_result  = pay_out[4:3];
   assign out_ioc     = pay_out[2];
   assign out_short   = pay_out[1];
   assign out_usb_err = pay_out[0];
endmodule

// File: rtl/td_complete_updater_chk.sv
module td_complete_updater_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        out_valid,
   input logic        out_ready,
   input logic [31:0] out_ctrl,
   input logic [1:0]  out_result,
   input logic        out_ioc,
   input logic        out_short,
   input logic        out_usb_err
);
   // R7 / R5: a fatal verdict always carries babble and stall and retires the word
   assert_fatal_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_result == 2'd3) |-> (out_ctrl[20] && out_ctrl[22] && !out_ctrl[23] && out_usb_err));

   assert_short_skips_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_short) |-> (out_result == 2'd1 && !out_ctrl[23] && !out_usb_err));

   assert_pending_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_result == 2'd2) |-> (out_ctrl[23] && !out_usb_err && !out_ioc));

   assert_err_retires_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_usb_err) |-> !out_ctrl[23]);

   assert_iso_inactive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ctrl[25]) |-> !out_ctrl[23]);

   assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_ctrl) && $stable(out_result)
                                     && $stable(out_ioc) && $stable(out_short) && $stable(out_usb_err)));
endmodule

bind td_complete_updater td_complete_updater_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_ctrl   (out_ctrl),
   .out_result (out_result),
   .out_ioc    (out_ioc),
   .out_short  (out_short),
   .out_usb_err(out_usb_err)
);

// File: tb/test_td_complete_updater.sv
`timescale 1ns/1ps
module test_td_complete_updater;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_ctrl = '0;
   logic [31:0] in_token = '0;
   logic [2:0]  in_outcome = '0;
   logic [11:0] in_count = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_ctrl;
   logic [1:0]  out_result;
   logic        out_ioc, out_short, out_usb_err;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   td_complete_updater i_td_complete_updater (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_ctrl(in_ctrl), .in_token(in_token), .in_outcome(in_outcome), .in_count(in_count),
      .out_valid(out_valid), .out_ready(out_ready), .out_ctrl(out_ctrl),
      .out_result(out_result), .out_ioc(out_ioc), .out_short(out_short), .out_usb_err(out_usb_err)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         if (errors < 20) $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected behaviour derived from the requirement list
   task automatic model(input logic [31:0] c, input logic [31:0] tok, input logic [2:0] oc,
                        input logic [11:0] cnt, output logic [31:0] nc, output logic [1:0] res,
                        output logic [2:0] ev, output string tag);
      logic [11:0] mx;
      logic [7:0]  pid;
      logic [2:0]  e;
      logic [1:0]  ec;
      logic        ioc, sh, er;
      mx  = {1'b0, 11'(tok[31:21] + 11'd1)};           // R1
      pid = tok[7:0];
      nc = c; res = 2'd0; ioc = 0; sh = 0; er = 0;
      e = (oc > 3'd4) ? 3'd1 : oc;
      if (!c[23]) begin
         res = 2'd1; tag = "R2";
      end else begin
         if (e == 3'd3 && pid == 8'h2D) begin
            nc[19] = 1'b1; e = 3'd4; tag = "R9";
         end else tag = "";
         if (e == 3'd0) begin
            nc[10:0] = cnt[10:0] - 11'd1; nc[23] = 0; nc[19] = 0; ioc = c[24];
            if (pid == 8'h69 && cnt > mx) begin
               nc[20] = 1; nc[22] = 1; er = 1; res = 2'd3; tag = "R5 R1";
            end else if (c[29] && cnt < mx) begin
               sh = 1; res = 2'd1; tag = "R4 R1";
            end else tag = "R3";
         end else if (e == 3'd1) begin
            nc[22] = 1; nc[23] = 0; er = 1; ioc = c[24]; res = 2'd1; tag = "R6";
         end else if (e == 3'd2) begin
            nc[20] = 1; nc[22] = 1; nc[23] = 0; er = 1; ioc = c[24]; res = 2'd3; tag = "R7";
         end else if (e == 3'd3) begin
            nc[19] = 1; res = 2'd2; tag = "R8";
         end else begin
            nc[18] = 1; res = 2'd2;
            ec = c[28:27];
            if (ec == 0) begin
               if (tag == "") tag = "R11";
            end else begin
               ec = ec - 2'd1;
               if (tag == "") tag = "R10";
               if (ec == 0) begin
                  nc[23] = 0; er = 1; ioc = c[24]; res = 2'd1;
               end
            end
            nc[28:27] = ec;
         end
         if (c[25]) begin
            nc[23] = 0; if (res == 2'd2) res = 2'd1; tag = {tag, " R12"};
         end
      end
      ev = {ioc, sh, er};
   endtask

   task automatic run_one(input logic [31:0] c, input logic [31:0] tok, input logic [2:0] oc,
                          input logic [11:0] cnt);
      logic [31:0] nc;
      logic [1:0]  res;
      logic [2:0]  ev;
      string       tag;
      model(c, tok, oc, cnt, nc, res, ev, tag);
      @(negedge clk);
      in_ctrl = c; in_token = tok; in_outcome = oc; in_count = cnt; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid === 1'b1 && out_ctrl === nc && out_result === res
            && {out_ioc, out_short, out_usb_err} === ev,
            tag, {out_valid, 25'd0, out_result, out_ioc, out_short, out_usb_err, out_ctrl},
            {1'b1, 25'd0, res, ev, nc});
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [10:0] mfs [4];
      logic [7:0]  pids [3];
      mfs[0] = 11'h7FF; mfs[1] = 11'h000; mfs[2] = 11'h007; mfs[3] = 11'h3FF;
      pids[0] = 8'h69;  pids[1] = 8'hE1;  pids[2] = 8'h2D;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid === 1'b0 && in_ready === 1'b1, "R13 reset", {62'd0, out_valid, in_ready}, 64'd1);
      rst_n = 1'b1;

      for (int oc = 0; oc < 8; oc++)
         for (int a = 0; a < 2; a++)
            for (int io = 0; io < 2; io++)
               for (int sp = 0; sp < 2; sp++)
                  for (int is = 0; is < 2; is++)
                     for (int er = 0; er < 4; er++)
                        for (int p = 0; p < 3; p++)
                           for (int m = 0; m < 4; m++)
                              for (int k = 0; k < 4; k++) begin
                                 logic [31:0] c, tok;
                                 logic [11:0] mx, cnt;
                                 c = 32'h0000_0155;
                                 c[29] = sp[0]; c[28:27] = er[1:0]; c[25] = is[0];
                                 c[24] = io[0]; c[23] = a[0]; c[19] = io[0];
                                 tok = {mfs[m], 13'h0A5, pids[p]};
                                 mx = {1'b0, 11'(mfs[m] + 11'd1)};
                                 cnt = mx + 12'(k) - 12'd1;
                                 run_one(c, tok, 3'(oc), cnt);
                              end

      // backpressure hold (R13)
      @(negedge clk);
      out_ready = 1'b0;
      in_ctrl = 32'h0180_0000; in_token = {11'd3, 13'd0, 8'h69}; in_outcome = 3'd0; in_count = 12'd4;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(out_valid === 1'b1 && in_ready === 1'b0 && out_ctrl === 32'h0100_0003 && out_result === 2'd0,
            "R13 hold", {30'd0, out_valid, in_ready, out_ctrl}, {32'h2, 32'h0100_0003});
      out_ready = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0 && in_ready === 1'b1, "R13 drain", {62'd0, out_valid, in_ready}, 64'd1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule